// File: doc/BRIEF.md
# Tomasulo Reservation Station Array

This block holds the instruction window of a small dynamically scheduled core. It has five reservation stations, and each station is bound to one kind of functional unit. It also keeps a register status table that maps every architectural register to the station that will produce its next value, and a small architectural register file. At dispatch, an instruction takes the lowest free station of the unit it needs. Each source operand is captured either as a value or as the number of the producing station. The station number is the only rename tag, so no separate free list exists.

Functional units read a ready station's opcode and operands through a read port. When a unit finishes, it raises that station's done bit together with the result. One result per cycle goes out on the common data bus. Every station waiting on that tag takes the value. The register file is written only if the status table still names the broadcasting station, which means a younger writer has not renamed the register since. A store has no destination, so it frees its station without using the bus.

Top module: `rs_array`

## Requirements
- R1: After reset every station is free, `readyVec` and `cdbValid` are 0, no register is pending, and every architectural register reads 0.
- R2: Stations 0, 1 and 2 serve unit codes 0 (integer), 1 (load) and 2 (store). Stations 3 and 4 both serve code 3 (floating point). Dispatch takes the lowest-index free station of the requested code and reports it on `dispTag` in the same cycle.
- R3: `dispStall` is high in the same cycle whenever no station of `dispUnit` is free. A stalled dispatch changes no station and no status entry.
- R4: Each dispatched source whose register has no pending producer captures the register value. A source whose register is pending captures the producer tag. If that producer is broadcasting in the same cycle, the source captures the bus value instead.
- R5: A dispatch with a destination overwrites that register's status entry with the new station's tag. A second writer of the same register never stalls.
- R6: Bit i of `readyVec` is high exactly when station i is busy and neither of its source tags is pending.
- R7: On a broadcast, every station whose source tag matches clears that tag and captures the bus value.
- R8: When several ready stations that have a destination complete together, only the lowest-index one is broadcast (`cdbTag`, `cdbData`) and freed. The others stay busy.
- R9: A broadcast writes the register file and clears the status entry only if that entry still holds the broadcasting tag. Otherwise the register and its status are left as they were.
- R10: A broadcast frees its station. A dispatch in the same cycle may take that station.
- R11: A station dispatched with `dispHasDst` low frees on done without a broadcast, even when another station broadcasts in the same cycle.
- R12: A done bit for a station that is free or not ready is ignored. Bit i of `doneAck` marks each station freed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispUnit | input | 2 | Requested unit code |
| dispOp | input | OP_W | Opcode stored in the station |
| dispDst | input | log2(ARCH_N) | Destination register |
| dispHasDst | input | 1 | Instruction writes a register |
| dispSrc1 | input | log2(ARCH_N) | First source register |
| dispSrc2 | input | log2(ARCH_N) | Second source register |
| dispStall | output | 1 | No free station of the requested unit |
| dispTag | output | 3 | Station chosen for the dispatch |
| doneVec | input | 5 | Per-station completion strobes |
| doneData | input | 5*DATA_W | Per-station results, station i at bits i*DATA_W |
| readyVec | output | 5 | Stations ready to issue |
| doneAck | output | 5 | Stations freed this cycle |
| cdbValid | output | 1 | Broadcast valid |
| cdbTag | output | 3 | Broadcasting station |
| cdbData | output | DATA_W | Broadcast value |
| rdIdx | input | 3 | Station read select |
| rdOp | output | OP_W | Opcode of selected station |
| rdDst | output | log2(ARCH_N) | Destination of selected station |
| rdV1 | output | DATA_W | First operand value |
| rdV2 | output | DATA_W | Second operand value |
| archIdx | input | log2(ARCH_N) | Register read select |
| archData | output | DATA_W | Register value |
| archPending | output | 1 | Register has a pending producer |
| archTag | output | 3 | Pending producer tag |

## Verification
The bench targets four corner cases.

- A finished result whose register has since been renamed by a younger writer. A design that ignores the status check would overwrite the register with a stale value.
- A dispatch that reads a register in the same cycle as its producer's broadcast. A design that misses the bus bypass would wait forever on a tag that never comes again.
- A dispatch into the very station being freed, and simultaneous completions of two stations. Wrong arbitration would lose a result or broadcast two.
- A store completing beside a broadcasting station. A store that used the bus would hide the other result.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_N  = 5;
  localparam int TAG_W = $clog2(RS_N);

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_LD  = 2'd1,
    UNIT_ST  = 2'd2,
    UNIT_FP  = 2'd3
  } unit_e;

  // station-to-unit binding: the last stations share the FP unit type
  function automatic unit_e unitOf(input int idx);
    case (idx)
      0:       return UNIT_INT;
      1:       return UNIT_LD;
      2:       return UNIT_ST;
      default: return UNIT_FP;
    endcase
  endfunction

  typedef struct packed {
    logic             allocEn;
    logic [TAG_W-1:0] allocIdx;
    logic             cdbEn;
    logic [TAG_W-1:0] cdbIdx;
  } rs_strobe_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [1:0]       dispUnit,
  input  logic             dispHasDst,
  input  logic [RS_N-1:0]  doneVec,
  input  logic [RS_N-1:0]  srcPending,
  output rs_strobe_t       strb,
  output logic [RS_N-1:0]  busyVec,
  output logic [RS_N-1:0]  readyVec,
  output logic [RS_N-1:0]  freeNow,
  output logic             dispStall
);
  logic [RS_N-1:0] hasDst;
  logic [RS_N-1:0] typeMatch;
  logic [RS_N-1:0] accepted;
  logic [RS_N-1:0] bcastCand;
  logic [RS_N-1:0] avail;
  logic [RS_N-1:0] allocOh;
  logic            found;

  for (genvar g = 0; g < RS_N; g++) begin : g_type
    assign typeMatch[g] = (dispUnit == unitOf(g));
  end

  assign readyVec  = busyVec & ~srcPending;
  assign accepted  = doneVec & readyVec;
  assign bcastCand = accepted & hasDst;

  always_comb begin
    strb.cdbEn  = 1'b0;
    strb.cdbIdx = '0;
    for (int i = RS_N - 1; i >= 0; i--) begin
      if (bcastCand[i]) begin
        strb.cdbEn  = 1'b1;
        strb.cdbIdx = TAG_W'(i);
      end
    end
    freeNow = accepted & ~hasDst;
    if (strb.cdbEn) freeNow[strb.cdbIdx] = 1'b1;
  end

  assign avail = (~busyVec | freeNow) & typeMatch;

  always_comb begin
    found         = 1'b0;
    strb.allocIdx = '0;
    for (int i = RS_N - 1; i >= 0; i--) begin
      if (avail[i]) begin
        found         = 1'b1;
        strb.allocIdx = TAG_W'(i);
      end
    end
    strb.allocEn = dispValid && found;
    allocOh      = '0;
    if (strb.allocEn) allocOh[strb.allocIdx] = 1'b1;
  end

  assign dispStall = !found;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyVec <= '0;
      hasDst  <= '0;
    end else begin
      busyVec <= (busyVec & ~freeNow) | allocOh;
      if (strb.allocEn) hasDst[strb.allocIdx] <= dispHasDst;
    end
  end

  a_r10_alloc_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> busyVec[$past(strb.allocIdx)]);

  for (genvar g = 0; g < RS_N; g++) begin : g_chk
    a_r11_freed_idle: assert property (@(posedge clk) disable iff (!rstN)
      (freeNow[g] && !(strb.allocEn && strb.allocIdx == TAG_W'(g))) |=> !busyVec[g]);
    a_r12_free_not_done: assert property (@(posedge clk) disable iff (!rstN)
      (!busyVec[g] && !(strb.allocEn && strb.allocIdx == TAG_W'(g))) |=> !busyVec[g]);
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ARCH_N = 8,
  parameter int OP_W   = 4,
  localparam int AREG_W = $clog2(ARCH_N)
)(
  input  logic               clk,
  input  logic               rstN,
  input  rs_strobe_t         strb,
  input  logic [RS_N-1:0]    busyVec,
  input  logic [OP_W-1:0]    dispOp,
  input  logic [AREG_W-1:0]  dispDst,
  input  logic               dispHasDst,
  input  logic [AREG_W-1:0]  dispSrc1,
  input  logic [AREG_W-1:0]  dispSrc2,
  input  logic [RS_N*DATA_W-1:0] doneData,
  input  logic [TAG_W-1:0]   rdIdx,
  input  logic [AREG_W-1:0]  archIdx,
  output logic [RS_N-1:0]    srcPending,
  output logic [DATA_W-1:0]  cdbData,
  output logic [OP_W-1:0]    rdOp,
  output logic [AREG_W-1:0]  rdDst,
  output logic [DATA_W-1:0]  rdV1,
  output logic [DATA_W-1:0]  rdV2,
  output logic [DATA_W-1:0]  archData,
  output logic               archPending,
  output logic [TAG_W-1:0]   archTag
);
  logic [OP_W-1:0]   opQ  [RS_N];
  logic [AREG_W-1:0] dstQ [RS_N];
  logic              t1V  [RS_N];
  logic              t2V  [RS_N];
  logic [TAG_W-1:0]  t1Q  [RS_N];
  logic [TAG_W-1:0]  t2Q  [RS_N];
  logic [DATA_W-1:0] v1Q  [RS_N];
  logic [DATA_W-1:0] v2Q  [RS_N];
  logic [DATA_W-1:0] doneArr [RS_N];

  logic [DATA_W-1:0] regQ  [ARCH_N];
  logic              statV [ARCH_N];
  logic [TAG_W-1:0]  statT [ARCH_N];

  logic              s1Pend, s2Pend;
  logic [TAG_W-1:0]  s1Tag, s2Tag;
  logic [DATA_W-1:0] s1Val, s2Val;
  logic [AREG_W-1:0] wbDst;
  logic              wbLive;

  for (genvar g = 0; g < RS_N; g++) begin : g_unpack
    assign doneArr[g]    = doneData[g*DATA_W +: DATA_W];
    assign srcPending[g] = t1V[g] | t2V[g];
  end

  assign cdbData = strb.cdbEn ? doneArr[strb.cdbIdx] : '0;
  assign wbDst   = dstQ[strb.cdbIdx];
  assign wbLive  = strb.cdbEn && statV[wbDst] && (statT[wbDst] == strb.cdbIdx);

  // operand capture: register value, producer tag, or same-cycle bus value
  always_comb begin
    s1Tag  = statT[dispSrc1];
    s1Pend = statV[dispSrc1] && !(strb.cdbEn && s1Tag == strb.cdbIdx);
    s1Val  = !statV[dispSrc1] ? regQ[dispSrc1] : (s1Pend ? '0 : cdbData);
    s2Tag  = statT[dispSrc2];
    s2Pend = statV[dispSrc2] && !(strb.cdbEn && s2Tag == strb.cdbIdx);
    s2Val  = !statV[dispSrc2] ? regQ[dispSrc2] : (s2Pend ? '0 : cdbData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ARCH_N; r++) begin
        regQ[r]  <= '0;
        statV[r] <= 1'b0;
        statT[r] <= '0;
      end
    end else begin
      if (wbLive) begin
        regQ[wbDst]  <= cdbData;
        statV[wbDst] <= 1'b0;
      end
      if (strb.allocEn && dispHasDst) begin
        statV[dispDst] <= 1'b1;
        statT[dispDst] <= strb.allocIdx;
      end
    end
  end

  for (genvar g = 0; g < RS_N; g++) begin : g_entry
    logic isAlloc;
    assign isAlloc = strb.allocEn && (strb.allocIdx == TAG_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opQ[g] <= '0; dstQ[g] <= '0;
        t1V[g] <= 1'b0; t2V[g] <= 1'b0;
        t1Q[g] <= '0; t2Q[g] <= '0;
        v1Q[g] <= '0; v2Q[g] <= '0;
      end else if (isAlloc) begin
        opQ[g] <= dispOp; dstQ[g] <= dispDst;
        t1V[g] <= s1Pend; t1Q[g] <= s1Tag; v1Q[g] <= s1Val;
        t2V[g] <= s2Pend; t2Q[g] <= s2Tag; v2Q[g] <= s2Val;
      end else begin
        if (strb.cdbEn && t1V[g] && t1Q[g] == strb.cdbIdx) begin
          t1V[g] <= 1'b0; v1Q[g] <= cdbData;
        end
        if (strb.cdbEn && t2V[g] && t2Q[g] == strb.cdbIdx) begin
          t2V[g] <= 1'b0; v2Q[g] <= cdbData;
        end
      end
    end

    a_r6_wait_live: assert property (@(posedge clk) disable iff (!rstN)
      (t1V[g] || t2V[g]) |-> busyVec[g]);
    a_r4_tag1_live: assert property (@(posedge clk) disable iff (!rstN)
      t1V[g] |-> busyVec[t1Q[g]]);
    a_r7_snoop_capture: assert property (@(posedge clk) disable iff (!rstN)
      (strb.cdbEn && t1V[g] && t1Q[g] == strb.cdbIdx && !isAlloc)
        |=> (!t1V[g] && v1Q[g] == $past(cdbData)));
  end

  for (genvar r = 0; r < ARCH_N; r++) begin : g_stat_chk
    a_r9_status_live: assert property (@(posedge clk) disable iff (!rstN)
      statV[r] |-> busyVec[statT[r]]);
  end

  assign rdOp        = opQ[rdIdx];
  assign rdDst       = dstQ[rdIdx];
  assign rdV1        = v1Q[rdIdx];
  assign rdV2        = v2Q[rdIdx];
  assign archData    = regQ[archIdx];
  assign archPending = statV[archIdx];
  assign archTag     = statT[archIdx];
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ARCH_N = 8,
  parameter int OP_W   = 4,
  localparam int AREG_W = $clog2(ARCH_N)
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispValid,
  input  logic [1:0]             dispUnit,
  input  logic [OP_W-1:0]        dispOp,
  input  logic [AREG_W-1:0]      dispDst,
  input  logic                   dispHasDst,
  input  logic [AREG_W-1:0]      dispSrc1,
  input  logic [AREG_W-1:0]      dispSrc2,
  output logic                   dispStall,
  output logic [TAG_W-1:0]       dispTag,
  input  logic [RS_N-1:0]        doneVec,
  input  logic [RS_N*DATA_W-1:0] doneData,
  output logic [RS_N-1:0]        readyVec,
  output logic [RS_N-1:0]        doneAck,
  output logic                   cdbValid,
  output logic [TAG_W-1:0]       cdbTag,
  output logic [DATA_W-1:0]      cdbData,
  input  logic [TAG_W-1:0]       rdIdx,
  output logic [OP_W-1:0]        rdOp,
  output logic [AREG_W-1:0]      rdDst,
  output logic [DATA_W-1:0]      rdV1,
  output logic [DATA_W-1:0]      rdV2,
  input  logic [AREG_W-1:0]      archIdx,
  output logic [DATA_W-1:0]      archData,
  output logic                   archPending,
  output logic [TAG_W-1:0]       archTag
);
  rs_strobe_t      strb;
  logic [RS_N-1:0] busyVec;
  logic [RS_N-1:0] srcPending;

  rs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispUnit(dispUnit),
    .dispHasDst(dispHasDst), .doneVec(doneVec), .srcPending(srcPending),
    .strb(strb), .busyVec(busyVec), .readyVec(readyVec), .freeNow(doneAck),
    .dispStall(dispStall)
  );

  rs_datapath #(.DATA_W(DATA_W), .ARCH_N(ARCH_N), .OP_W(OP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busyVec(busyVec),
    .dispOp(dispOp), .dispDst(dispDst), .dispHasDst(dispHasDst),
    .dispSrc1(dispSrc1), .dispSrc2(dispSrc2), .doneData(doneData),
    .rdIdx(rdIdx), .archIdx(archIdx), .srcPending(srcPending),
    .cdbData(cdbData), .rdOp(rdOp), .rdDst(rdDst), .rdV1(rdV1), .rdV2(rdV2),
    .archData(archData), .archPending(archPending), .archTag(archTag)
  );

  assign dispTag  = strb.allocIdx;
  assign cdbValid = strb.cdbEn;
  assign cdbTag   = strb.cdbIdx;
endmodule

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 0, rstN = 0;
  logic dispValid = 0, dispHasDst = 0;
  logic [1:0] dispUnit = 0;
  logic [3:0] dispOp = 0;
  logic [2:0] dispDst = 0, dispSrc1 = 0, dispSrc2 = 0, archIdx = 0, rdIdx = 0;
  logic [4:0] doneVec = 0;
  logic [DW-1:0] dd [5];
  logic [5*DW-1:0] doneData;
  logic dispStall, cdbValid, archPending;
  logic [2:0] dispTag, cdbTag, archTag, rdDst;
  logic [4:0] readyVec, doneAck;
  logic [DW-1:0] cdbData, rdV1, rdV2, archData;
  logic [3:0] rdOp;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_comb for (int i = 0; i < 5; i++) doneData[i*DW +: DW] = dd[i];

  rs_array dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic disp(input int u, input int op, input int dst, input bit hd, input int s1, input int s2);
    dispValid = 1; dispUnit = 2'(u); dispOp = 4'(op); dispDst = 3'(dst);
    dispHasDst = hd; dispSrc1 = 3'(s1); dispSrc2 = 3'(s2);
  endtask

  task automatic tick;
    @(posedge clk); #1;
    dispValid = 0; doneVec = 0;
    for (int i = 0; i < 5; i++) dd[i] = '0;
    #3;
  endtask

  task automatic reg_is(input string req, input int r, input int val, input bit pend, input int tag);
    archIdx = 3'(r); #1;
    eq(req, archData, val);
    eq(req, archPending, pend);
    if (pend) eq(req, archTag, tag);
  endtask

  task automatic ent_is(input string req, input int e, input int a, input int b);
    rdIdx = 3'(e); #1;
    eq(req, rdV1, a);
    eq(req, rdV2, b);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) dd[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1; #3;
    // R1 reset state
    eq("R1", readyVec, 0);
    eq("R1", cdbValid, 0);
    for (int r = 0; r < 8; r++) reg_is("R1", r, 0, 0, 0);
    for (int u = 0; u < 4; u++) begin dispUnit = 2'(u); #1; eq("R1", dispStall, 0); end

    // integer op r1 <- r2,r3
    disp(0, 1, 1, 1, 2, 3); #1;
    eq("R2", dispTag, 0); eq("R3", dispStall, 0);
    tick();
    reg_is("R5", 1, 0, 1, 0);
    eq("R6", readyVec, 5'b00001);
    rdIdx = 0; #1; eq("R2", rdOp, 1); eq("R2", rdDst, 1);

    doneVec = 5'b00001; dd[0] = 16'h0011; #1;
    eq("R8", cdbValid, 1); eq("R8", cdbTag, 0); eq("R8", cdbData, 16'h0011);
    eq("R12", doneAck, 5'b00001);
    tick();
    reg_is("R9", 1, 16'h0011, 0, 0);
    eq("R10", readyVec, 0);

    disp(1, 2, 2, 1, 1, 1); #1; eq("R2", dispTag, 1);
    tick();
    ent_is("R4", 1, 16'h0011, 16'h0011);
    disp(3, 3, 3, 1, 2, 1); #1; eq("R2", dispTag, 3);
    tick();
    reg_is("R5", 3, 0, 1, 3);
    eq("R6", readyVec, 5'b00010);
    rdIdx = 3; #1; eq("R4", rdV2, 16'h0011);
    disp(3, 4, 3, 1, 3, 2); #1; eq("R5", dispTag, 4); eq("R5", dispStall, 0);
    tick();
    reg_is("R5", 3, 0, 1, 4);
    disp(3, 5, 5, 1, 0, 0); #1; eq("R3", dispStall, 1);
    tick();
    reg_is("R3", 5, 0, 0, 0);
    reg_is("R3", 3, 0, 1, 4);
    eq("R3", readyVec, 5'b00010);

    // load result with ignored done bits and same-cycle bus capture at dispatch
    doneVec = 5'b01111; dd[1] = 16'h0022; dd[3] = 16'h0077;
    disp(0, 6, 6, 1, 2, 0); #1;
    eq("R12", doneAck, 5'b00010); eq("R8", cdbTag, 1); eq("R8", cdbData, 16'h0022);
    eq("R2", dispTag, 0);
    tick();
    eq("R7", readyVec, 5'b01001);
    ent_is("R7", 3, 16'h0022, 16'h0011);
    ent_is("R4", 0, 16'h0022, 0);
    reg_is("R9", 2, 16'h0022, 0, 0);
    rdIdx = 4; #1; eq("R7", rdV2, 16'h0022);

    doneVec = 5'b01001; dd[0] = 16'h0044; dd[3] = 16'h0033; #1;
    eq("R8", cdbTag, 0); eq("R8", cdbData, 16'h0044); eq("R8", doneAck, 5'b00001);
    tick();
    reg_is("R8", 6, 16'h0044, 0, 0);
    eq("R8", readyVec, 5'b01000);

    // stale writer broadcast + reuse of freed station
    doneVec = 5'b01000; dd[3] = 16'h0033;
    disp(3, 7, 7, 1, 3, 0); #1;
    eq("R10", dispStall, 0); eq("R10", dispTag, 3); eq("R8", cdbTag, 3);
    tick();
    reg_is("R9", 3, 0, 1, 4);
    reg_is("R10", 7, 0, 1, 3);
    eq("R7", readyVec, 5'b10000);
    ent_is("R7", 4, 16'h0033, 16'h0022);
    ent_is("R4", 3, 0, 0);

    // store path
    disp(2, 8, 0, 0, 1, 2); #1; eq("R2", dispTag, 2);
    tick();
    eq("R11", readyVec, 5'b10100);
    ent_is("R4", 2, 16'h0011, 16'h0022);
    reg_is("R11", 0, 0, 0, 0);
    doneVec = 5'b00100; dd[2] = 16'h0099; #1;
    eq("R11", cdbValid, 0); eq("R11", doneAck, 5'b00100);
    tick();
    eq("R11", readyVec, 5'b10000);
    dispUnit = 2; #1; eq("R11", dispStall, 0); eq("R11", dispTag, 2);
    disp(2, 9, 0, 0, 0, 0); tick();
    doneVec = 5'b10100; dd[2] = 16'h00aa; dd[4] = 16'h0055; #1;
    eq("R11", cdbTag, 4); eq("R11", cdbData, 16'h0055); eq("R11", doneAck, 5'b10100);
    tick();
    reg_is("R9", 3, 16'h0055, 0, 0);
    eq("R7", readyVec, 5'b01000);
    ent_is("R7", 3, 16'h0055, 0);

    doneVec = 5'b01000; dd[3] = 16'h0066; tick();
    reg_is("R9", 7, 16'h0066, 0, 0);
    reg_is("R9", 3, 16'h0055, 0, 0);
    eq("R6", readyVec, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule